// File: doc/BRIEF.md
# Configuration Bus Command Bridge

This block lets a host processor run single read or write transactions on a board configuration bus through three memory-mapped registers. The host loads a data word and clears the status flags. It then writes a command word whose top bit starts the transaction. The command word packs a write flag with the target address fields: controller, function, site, stack position and device number.

The bridge holds the command and presents it on a request/acknowledge interface on the device side. It keeps that request up until the device answers or a programmable timeout runs out. When the transaction ends, the start bit drops and a status flag records success or failure. On a successful read, the device's returned word replaces the data register. Software polls the start bit to see whether the bridge is busy. Writes that would disturb a running transaction are discarded.

Top module: `cfgb_bridge`

## Requirements
- R1: After reset the data, command and status registers all read zero and no request is raised. The registers read back at offsets 0x0A0 (data), 0x0A4 (command) and 0x0A8 (status), and any other offset reads zero.
- R2: A command write with bit 31 set while idle stores the whole word and raises dev_req. dev_cmd carries that word: bit 31 start, bit 30 write (1 write, 0 read), bits 29:26 controller, bits 25:20 function, bits 17:16 site, bits 15:12 stack position, bits 11:0 device. dev_wdata carries the data register.
- R3: Bit 31 of the command register reads 1 for as long as the transaction runs. It clears on the same clock edge that sets a status flag.
- R4: An acknowledge with dev_err low sets status to 0x1 (bit 0 complete, bit 1 error).
- R5: A read command acknowledged without error loads dev_rdata into the data register.
- R6: A write command leaves the data register holding the host-written value after completion.
- R7: An acknowledge with dev_err high sets status to 0x2 and leaves the data register unchanged.
- R8: Writes to the command or data register while bit 31 is set are ignored.
- R9: Any write to the status register clears both flags.
- R10: When tmo_limit is nonzero and no acknowledge arrives within tmo_limit busy cycles, the transaction ends with status 0x2 and bit 31 cleared. When tmo_limit is zero, the bridge waits without limit.
- R11: dev_ack while no transaction runs changes no register.
- R12: A command write with bit 31 clear stores the word without raising a request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_sel | input | 1 | Host access select |
| host_wr | input | 1 | Host write strobe (with host_sel) |
| host_addr | input | 12 | Register offset |
| host_wdata | input | 32 | Host write data |
| host_rdata | output | 32 | Register selected by host_addr |
| tmo_limit | input | TMO_W | Busy cycles allowed before timeout, 0 disables |
| dev_req | output | 1 | Transaction pending toward device |
| dev_cmd | output | 32 | Command word toward device |
| dev_wdata | output | 32 | Data word toward device |
| dev_ack | input | 1 | Device response strobe |
| dev_err | input | 1 | Device reports failure with dev_ack |
| dev_rdata | input | 32 | Device read data with dev_ack |

## Verification
The core sequence is run from a vector table. The table mixes reads and writes, successful and failing answers, different address field values, and response delays from zero cycles to several. These cases separate the read-load path from the write-keep path, and the error status from the complete status. Directed cases then try a command rewrite and a data rewrite during busy, a stray acknowledge while idle, and a status clear. A timeout is tested at its exact edge, and a disabled timeout is tested with a long wait. These cases show whether guarding, clearing and counting start and stop on the right cycle.

// File: rtl/cfgb_pkg.sv
package cfgb_pkg;
  localparam int unsigned HADDR_W = 12;
  localparam int unsigned DW      = 32;

  localparam logic [HADDR_W-1:0] OFF_DATA = 12'h0A0;
  localparam logic [HADDR_W-1:0] OFF_CTRL = 12'h0A4;
  localparam logic [HADDR_W-1:0] OFF_STAT = 12'h0A8;

  localparam int unsigned BIT_GO = 31;
  localparam int unsigned BIT_WR = 30;

  typedef struct packed {
    logic err;
    logic ok;
  } stat_t;
endpackage

// File: rtl/cfgb_rst_sync.sv
module cfgb_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_q_n
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_q_n = sync_q[1];
endmodule

// File: rtl/cfgb_decode.sv
module cfgb_decode
  import cfgb_pkg::*;
(
  input  logic               host_sel,
  input  logic               host_wr,
  input  logic [HADDR_W-1:0] host_addr,
  input  logic [DW-1:0]      data_q,
  input  logic [DW-1:0]      ctrl_q,
  input  stat_t              stat_q,
  output logic               wr_data,
  output logic               wr_ctrl,
  output logic               wr_stat,
  output logic [DW-1:0]      rdata
);
  logic wr_any;
  assign wr_any  = host_sel && host_wr;
  assign wr_data = wr_any && (host_addr == OFF_DATA);
  assign wr_ctrl = wr_any && (host_addr == OFF_CTRL);
  assign wr_stat = wr_any && (host_addr == OFF_STAT);

  always_comb begin
    case (host_addr)
      OFF_DATA: rdata = data_q;
      OFF_CTRL: rdata = ctrl_q;
      OFF_STAT: rdata = {{(DW-2){1'b0}}, stat_q};
      default:  rdata = '0;
    endcase
  end
endmodule

// File: rtl/cfgb_seq.sv
module cfgb_seq #(
  parameter int unsigned TMO_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             busy,
  input  logic             dev_ack,
  input  logic             dev_err,
  input  logic [TMO_W-1:0] tmo_limit,
  output logic             done,
  output logic             done_err
);
  localparam logic [TMO_W-1:0] ONE = 1;

  logic [TMO_W-1:0] cnt_q, cnt_d;
  logic             cnt_en;
  logic             tmo_hit;

  assign tmo_hit  = busy && !dev_ack && (tmo_limit != '0) && (cnt_q == tmo_limit - ONE);
  assign done     = busy && (dev_ack || tmo_hit);
  assign done_err = busy && ((dev_ack && dev_err) || tmo_hit);

  always_comb begin
    cnt_en = 1'b0;
    cnt_d  = cnt_q;
    if (!busy) begin
      cnt_en = (cnt_q != '0);
      cnt_d  = '0;
    end else if (!dev_ack) begin
      cnt_en = 1'b1;
      cnt_d  = cnt_q + ONE;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end
endmodule

// File: rtl/cfgb_regfile.sv
module cfgb_regfile
  import cfgb_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_data,
  input  logic          wr_ctrl,
  input  logic          wr_stat,
  input  logic [DW-1:0] wdata,
  input  logic          done,
  input  logic          done_err,
  input  logic [DW-1:0] dev_rdata,
  output logic [DW-1:0] data_q,
  output logic [DW-1:0] ctrl_q,
  output stat_t         stat_q
);
  logic [DW-1:0] data_d, ctrl_d;
  stat_t         stat_d;
  logic          data_en, ctrl_en, stat_en;
  logic          busy;

  assign busy = ctrl_q[BIT_GO];

  always_comb begin
    data_en = 1'b0;
    data_d  = data_q;
    if (done && !done_err && !ctrl_q[BIT_WR]) begin
      data_en = 1'b1;
      data_d  = dev_rdata;
    end else if (wr_data && !busy) begin
      data_en = 1'b1;
      data_d  = wdata;
    end

    ctrl_en = 1'b0;
    ctrl_d  = ctrl_q;
    if (done) begin
      ctrl_en        = 1'b1;
      ctrl_d[BIT_GO] = 1'b0;
    end else if (wr_ctrl && !busy) begin
      ctrl_en = 1'b1;
      ctrl_d  = wdata;
    end

    stat_en = 1'b0;
    stat_d  = stat_q;
    if (done) begin
      stat_en    = 1'b1;
      stat_d.err = done_err;
      stat_d.ok  = !done_err;
    end else if (wr_stat) begin
      stat_en = 1'b1;
      stat_d  = '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       data_q <= '0;
    else if (data_en) data_q <= data_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       ctrl_q <= '0;
    else if (ctrl_en) ctrl_q <= ctrl_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       stat_q <= '0;
    else if (stat_en) stat_q <= stat_d;
  end
endmodule

// File: rtl/cfgb_bridge.sv
module cfgb_bridge
  import cfgb_pkg::*;
#(
  parameter int unsigned TMO_W = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               host_sel,
  input  logic               host_wr,
  input  logic [HADDR_W-1:0] host_addr,
  input  logic [DW-1:0]      host_wdata,
  output logic [DW-1:0]      host_rdata,
  input  logic [TMO_W-1:0]   tmo_limit,
  output logic               dev_req,
  output logic [DW-1:0]      dev_cmd,
  output logic [DW-1:0]      dev_wdata,
  input  logic               dev_ack,
  input  logic               dev_err,
  input  logic [DW-1:0]      dev_rdata
);
  logic          rst_q_n;
  logic          wr_data, wr_ctrl, wr_stat;
  logic          done, done_err;
  logic [DW-1:0] data_q, ctrl_q;
  stat_t         stat_q;

  cfgb_rst_sync u_rst (
    .clk     (clk),
    .rst_n   (rst_n),
    .rst_q_n (rst_q_n)
  );

  cfgb_decode u_dec (
    .host_sel  (host_sel),
    .host_wr   (host_wr),
    .host_addr (host_addr),
    .data_q    (data_q),
    .ctrl_q    (ctrl_q),
    .stat_q    (stat_q),
    .wr_data   (wr_data),
    .wr_ctrl   (wr_ctrl),
    .wr_stat   (wr_stat),
    .rdata     (host_rdata)
  );

  cfgb_seq #(.TMO_W(TMO_W)) u_seq (
    .clk       (clk),
    .rst_n     (rst_q_n),
    .busy      (ctrl_q[BIT_GO]),
    .dev_ack   (dev_ack),
    .dev_err   (dev_err),
    .tmo_limit (tmo_limit),
    .done      (done),
    .done_err  (done_err)
  );

  cfgb_regfile u_regs (
    .clk       (clk),
    .rst_n     (rst_q_n),
    .wr_data   (wr_data),
    .wr_ctrl   (wr_ctrl),
    .wr_stat   (wr_stat),
    .wdata     (host_wdata),
    .done      (done),
    .done_err  (done_err),
    .dev_rdata (dev_rdata),
    .data_q    (data_q),
    .ctrl_q    (ctrl_q),
    .stat_q    (stat_q)
  );

  assign dev_req   = ctrl_q[BIT_GO];
  assign dev_cmd   = ctrl_q;
  assign dev_wdata = data_q;
endmodule

// File: rtl/cfgb_bridge_chk.sv
module cfgb_bridge_chk #(
  parameter int unsigned TMO_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             dev_req,
  input logic [31:0]      dev_cmd,
  input logic [31:0]      dev_wdata,
  input logic             dev_ack,
  input logic             dev_err,
  input logic [31:0]      dev_rdata,
  input logic [TMO_W-1:0] tmo_limit,
  input logic [1:0]       stat_q
);
  logic [TMO_W:0] wait_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                        wait_cnt <= '0;
    else if (!dev_req)                 wait_cnt <= '0;
    else if (!dev_ack && !wait_cnt[TMO_W]) wait_cnt <= wait_cnt + 1'b1;
  end

  assert_done_clears_start_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (dev_req && dev_ack) |=> (!dev_req && (stat_q != 2'b00)));

  assert_ok_status_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (dev_req && dev_ack && !dev_err) |=> (stat_q == 2'b01));

  assert_read_load_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (dev_req && dev_ack && !dev_err && !dev_cmd[30]) |=> (dev_wdata == $past(dev_rdata)));

  assert_write_keep_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (dev_req && dev_ack && dev_cmd[30]) |=> $stable(dev_wdata));

  assert_err_status_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (dev_req && dev_ack && dev_err) |=> (stat_q == 2'b10));

  assert_busy_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    dev_req |=> (!dev_req || ($stable(dev_cmd) && $stable(dev_wdata))));

  assert_timeout_bound_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (dev_req && (tmo_limit != '0)) |-> (wait_cnt < {1'b0, tmo_limit}));
endmodule

bind cfgb_bridge cfgb_bridge_chk #(.TMO_W(TMO_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_q_n),
  .dev_req   (dev_req),
  .dev_cmd   (dev_cmd),
  .dev_wdata (dev_wdata),
  .dev_ack   (dev_ack),
  .dev_err   (dev_err),
  .dev_rdata (dev_rdata),
  .tmo_limit (tmo_limit),
  .stat_q    (stat_q)
);

// File: tb/cfgb_bridge_bench.sv
`timescale 1ns/1ps
module cfgb_bridge_bench;
  localparam int TW = 16;
  localparam logic [11:0] A_DATA = 12'h0A0;
  localparam logic [11:0] A_CTRL = 12'h0A4;
  localparam logic [11:0] A_STAT = 12'h0A8;

  typedef struct packed {
    logic        wr;
    logic [3:0]  ctl;
    logic [5:0]  fn;
    logic [1:0]  site;
    logic [3:0]  pos;
    logic [11:0] devn;
    logic [31:0] wdata;
    logic [7:0]  dly;
    logic        err;
    logic [31:0] rdata;
  } vec_t;

  localparam int NV = 6;
  localparam vec_t VECS [NV] = '{
    '{1'b0, 4'h1, 6'h01, 2'd1, 4'h0, 12'h000, 32'h1111_1111, 8'd2, 1'b0, 32'hCAFE_0001},
    '{1'b1, 4'h0, 6'h02, 2'd2, 4'h3, 12'h004, 32'hA5A5_5A5A, 8'd0, 1'b0, 32'h0BAD_F00D},
    '{1'b0, 4'hF, 6'h3F, 2'd3, 4'hF, 12'hFFF, 32'h2222_2222, 8'd3, 1'b1, 32'hBAD0_BAD0},
    '{1'b1, 4'h7, 6'h15, 2'd0, 4'h8, 12'h123, 32'h3333_3333, 8'd1, 1'b1, 32'h4444_4444},
    '{1'b0, 4'h2, 6'h07, 2'd1, 4'h1, 12'h800, 32'hFFFF_FFFF, 8'd7, 1'b0, 32'h0000_0000},
    '{1'b0, 4'h9, 6'h20, 2'd2, 4'h6, 12'h055, 32'h0000_0000, 8'd0, 1'b0, 32'h8000_0001}
  };

  logic          clk = 1'b0;
  logic          rst_n;
  logic          host_sel, host_wr;
  logic [11:0]   host_addr;
  logic [31:0]   host_wdata, host_rdata;
  logic [TW-1:0] tmo_limit;
  logic          dev_req, dev_ack, dev_err;
  logic [31:0]   dev_cmd, dev_wdata, dev_rdata;

  int n_chk = 0;
  int n_bad = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;

  cfgb_bridge #(.TMO_W(TW)) u_cfgb_bridge (
    .clk(clk), .rst_n(rst_n), .host_sel(host_sel), .host_wr(host_wr),
    .host_addr(host_addr), .host_wdata(host_wdata), .host_rdata(host_rdata),
    .tmo_limit(tmo_limit), .dev_req(dev_req), .dev_cmd(dev_cmd),
    .dev_wdata(dev_wdata), .dev_ack(dev_ack), .dev_err(dev_err),
    .dev_rdata(dev_rdata)
  );

  function automatic logic [31:0] mk_cmd(input vec_t v);
    return {1'b1, v.wr, v.ctl, v.fn, 2'b00, v.site, v.pos, v.devn};
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  task automatic hwrite(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    host_sel = 1'b1; host_wr = 1'b1; host_addr = a; host_wdata = d;
    @(negedge clk);
    host_sel = 1'b0; host_wr = 1'b0;
  endtask

  task automatic hread(input logic [11:0] a, output logic [31:0] d);
    host_addr = a;
    #0.5;
    d = host_rdata;
  endtask

  task automatic respond(input int dly, input logic e, input logic [31:0] rd);
    for (int i = 0; i < dly; i++) @(negedge clk);
    dev_ack = 1'b1; dev_err = e; dev_rdata = rd;
    @(negedge clk);
    dev_ack = 1'b0; dev_err = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] r;
    logic [31:0] cmd;
    logic [31:0] exp_data;
    rst_n = 1'b0; host_sel = 1'b0; host_wr = 1'b0; host_addr = '0;
    host_wdata = '0; tmo_limit = TW'(100); dev_ack = 1'b0; dev_err = 1'b0;
    dev_rdata = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R1 reset state
    hread(A_DATA, r); check("R1 data reset", r, 32'h0);
    hread(A_CTRL, r); check("R1 ctrl reset", r, 32'h0);
    hread(A_STAT, r); check("R1 stat reset", r, 32'h0);
    check("R1 no request", {31'b0, dev_req}, 32'h0);

    // vector table
    for (int k = 0; k < NV; k++) begin
      cmd = mk_cmd(VECS[k]);
      hwrite(A_DATA, VECS[k].wdata);
      hwrite(A_STAT, 32'h0);
      hwrite(A_CTRL, cmd);
      check("R2 dev_req", {31'b0, dev_req}, 32'h1);
      check("R2 dev_cmd", dev_cmd, cmd);
      check("R2 dev_wdata", dev_wdata, VECS[k].wdata);
      hread(A_CTRL, r); check("R3 start reads 1", r, cmd);
      respond(int'(VECS[k].dly), VECS[k].err, VECS[k].rdata);
      hread(A_CTRL, r); check("R3 start cleared", r, cmd & 32'h7FFF_FFFF);
      hread(A_STAT, r);
      check(VECS[k].err ? "R7 error status" : "R4 complete status", r,
            VECS[k].err ? 32'h2 : 32'h1);
      exp_data = (!VECS[k].wr && !VECS[k].err) ? VECS[k].rdata : VECS[k].wdata;
      hread(A_DATA, r);
      check(VECS[k].wr ? "R6 write keeps data" :
            (VECS[k].err ? "R7 data unchanged" : "R5 read data"), r, exp_data);
    end

    // R9 any status write clears
    hwrite(A_STAT, 32'hFFFF_FFFF);
    hread(A_STAT, r); check("R9 status cleared", r, 32'h0);

    // R1 unmapped offset
    hread(12'h0AC, r); check("R1 unmapped reads 0", r, 32'h0);

    // R12 command without start
    hwrite(A_CTRL, 32'h0123_4567);
    hread(A_CTRL, r); check("R12 stored", r, 32'h0123_4567);
    check("R12 no request", {31'b0, dev_req}, 32'h0);

    // R8 writes ignored while busy
    hwrite(A_DATA, 32'h5555_0000);
    hwrite(A_CTRL, 32'h8000_0042);
    hwrite(A_DATA, 32'h6666_6666);
    hwrite(A_CTRL, 32'hC000_0099);
    hread(A_CTRL, r); check("R8 ctrl held", r, 32'h8000_0042);
    hread(A_DATA, r); check("R8 data held", r, 32'h5555_0000);
    respond(0, 1'b0, 32'h7777_7777);
    hread(A_DATA, r); check("R5 read after guard", r, 32'h7777_7777);

    // R11 stray ack while idle
    hwrite(A_STAT, 32'h0);
    respond(0, 1'b1, 32'h1234_5678);
    hread(A_STAT, r); check("R11 status untouched", r, 32'h0);
    hread(A_DATA, r); check("R11 data untouched", r, 32'h7777_7777);
    hread(A_CTRL, r); check("R11 ctrl untouched", r, 32'h0000_0042);

    // R10 timeout at exactly tmo_limit busy cycles
    tmo_limit = TW'(5);
    hwrite(A_CTRL, 32'h8000_0010);
    repeat (4) @(negedge clk);
    hread(A_CTRL, r); check("R10 still busy", r, 32'h8000_0010);
    @(negedge clk);
    hread(A_CTRL, r); check("R10 timed out", r, 32'h0000_0010);
    hread(A_STAT, r); check("R10 error status", r, 32'h2);

    // R10 limit zero waits
    tmo_limit = '0;
    hwrite(A_STAT, 32'h0);
    hwrite(A_CTRL, 32'h8000_0011);
    repeat (40) @(negedge clk);
    check("R10 no timeout when 0", {31'b0, dev_req}, 32'h1);
    respond(0, 1'b0, 32'h0000_00AB);
    hread(A_STAT, r); check("R4 late complete", r, 32'h1);

    finished = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule